// File: doc/BRIEF.md
# I2C Bus Arbitration Monitor

This block sits beside the bit engine of an I2C master that shares its bus with other masters. It watches the synchronized SCL and SDA line levels. From them it keeps a bus-busy flag, which a START sets and a STOP clears. A new START request from the master is granted only while that flag is low.

While the bus is busy, the block compares the level the master means to put on SDA with the level actually seen on the wire. It makes this comparison once per clock-high phase, at the rising edge of SCL. The check runs through every bit of a transfer, so it covers the address and, when two masters address the same target, the data bits that follow.

A master that wants SDA high but sees it low has lost arbitration. When that happens, the block raises a one-cycle arbitration-lost pulse. It also asserts a force-release level that switches off the master's SDA driver. Force-release stays asserted until a STOP returns the bus to idle.

Top module: `i2c_arb_monitor`

## Requirements
- R1: After reset, bus_busy, arb_lost and force_release are 0, and sda_oe_o follows mst_sda_oe.
- R2: SDA falling from 1 to 0 between two consecutive clock samples, with SCL at 1 in both, sets bus_busy one clock later.
- R3: SDA rising from 0 to 1 between two consecutive clock samples, with SCL at 1 in both, clears bus_busy one clock later.
- R4: SDA changes while SCL is 0 leave bus_busy unchanged, whether the bus is idle or busy.
- R5: start_grant equals start_req while bus_busy and force_release are both 0, and is 0 otherwise.
- R6: At the clock where SCL is first seen at 1 after being 0, with bus_busy set, mst_sda_oe at 1, mst_sda_out at 1 and sda_in at 0, arb_lost is 1 for exactly the next clock.
- R7: No arb_lost pulse occurs when the SCL rise sees sda_in equal to mst_sda_out, when mst_sda_oe is 0, or when the bus is idle.
- R8: force_release rises together with arb_lost and falls in the same clock in which bus_busy clears. While it is 1, sda_oe_o is 0.
- R9: SDA is compared only at the SCL rising sample. A change of mst_sda_out later in the same SCL-high phase causes no arb_lost.
- R10: The comparison repeats on every bit of a transfer, so a first mismatch on the fourteenth bit after START (a data bit) is still reported.
- R11: While force_release is 1, no further arb_lost pulse is produced, even if mismatches continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized SCL line level |
| sda_in | input | 1 | Synchronized SDA line level |
| mst_sda_out | input | 1 | Level the master intends on SDA (1 = released high) |
| mst_sda_oe | input | 1 | Master is taking part in the current bit |
| start_req | input | 1 | Master asks to issue a START |
| start_grant | output | 1 | START request allowed (bus idle, not locked out) |
| sda_oe_o | output | 1 | Gated SDA driver enable for the pad |
| bus_busy | output | 1 | Bus is between a START and a STOP |
| arb_lost | output | 1 | One-cycle pulse on loss of arbitration |
| force_release | output | 1 | Master locked off SDA until the bus is idle |

## Verification
A wrong bus-busy state shows up at start_grant in the same cycle. It also shows at the next SCL rise, as a loss that is missed or wrongly reported. A stale SCL or SDA history register gives a false START or STOP, which shows on bus_busy one clock after the line edge. A stuck or early-cleared lockout shows on sda_oe_o and start_grant at once, and on a repeated arb_lost at the next mismatching bit. The bench therefore samples the outputs one clock after each line edge and again one bit later.

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic mst_sda_out,
  input  logic mst_sda_oe,
  input  logic start_req,
  output logic start_grant,
  output logic sda_oe_o,
  output logic bus_busy,
  output logic arb_lost,
  output logic force_release
);

  logic scl_q, sda_q;
  logic start_det, stop_det, scl_rise, lose_now;

  assign start_det = scl_q & scl_in & sda_q & ~sda_in;
  assign stop_det  = scl_q & scl_in & ~sda_q & sda_in;
  assign scl_rise  = ~scl_q & scl_in;
  assign lose_now  = scl_rise & bus_busy & ~force_release
                   & mst_sda_oe & mst_sda_out & ~sda_in;

  assign start_grant = start_req & ~bus_busy & ~force_release;
  assign sda_oe_o    = mst_sda_oe & ~force_release;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_busy <= 1'b0;
    else if (stop_det)  bus_busy <= 1'b0;
    else if (start_det) bus_busy <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_lost      <= 1'b0;
      force_release <= 1'b0;
    end else begin
      arb_lost <= lose_now;
      if (stop_det)      force_release <= 1'b0;
      else if (lose_now) force_release <= 1'b1;
    end
  end

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> bus_busy); // R2
  AST_BUSY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !bus_busy); // R3
  AST_LOST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> !arb_lost); // R6
  AST_LOST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> $past(bus_busy)); // R6
  AST_RELEASE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_release) |-> !bus_busy); // R8
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> !force_release); // R8
  AST_NO_RELOSS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_release) |-> !arb_lost); // R11

endmodule

// File: tb/test_i2c_arb_monitor.sv
module test_i2c_arb_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic mst_sda_out = 1'b1, mst_sda_oe = 1'b0, start_req = 1'b0;
  logic start_grant, sda_oe_o, bus_busy, arb_lost, force_release;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  i2c_arb_monitor i_i2c_arb_monitor (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .mst_sda_out(mst_sda_out), .mst_sda_oe(mst_sda_oe), .start_req(start_req),
    .start_grant(start_grant), .sda_oe_o(sda_oe_o), .bus_busy(bus_busy),
    .arb_lost(arb_lost), .force_release(force_release));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic tick(input logic s, input logic d);
    @(negedge clk);
    scl_in = s;
    sda_in = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_start();
    tick(1, 1); tick(1, 1); tick(1, 0); tick(0, 0);
  endtask

  task automatic do_stop();
    tick(0, 0); tick(1, 0); tick(1, 1);
  endtask

  task automatic bit_cycle(input logic mine, input logic line, output logic lost);
    mst_sda_out = mine;
    tick(0, line);
    tick(1, line);
    lost = arb_lost;
    tick(1, line);
    tick(0, line);
  endtask

  task automatic t_reset();
    chk("R1 busy", bus_busy, 1'b0);
    chk("R1 lost", arb_lost, 1'b0);
    chk("R1 release", force_release, 1'b0);
    mst_sda_oe = 1'b1; #1;
    chk("R1 oe", sda_oe_o, 1'b1);
    mst_sda_oe = 1'b0;
  endtask

  task automatic t_start_stop();
    start_req = 1'b1; #1;
    chk("R5 grant idle", start_grant, 1'b1);
    tick(1, 1); tick(1, 0);
    chk("R2 start", bus_busy, 1'b1);
    chk("R5 grant busy", start_grant, 1'b0);
    start_req = 1'b0;
    tick(0, 0); tick(1, 0); tick(1, 1);
    chk("R3 stop", bus_busy, 1'b0);
  endtask

  task automatic t_low_toggle();
    tick(0, 1); tick(0, 0); tick(0, 1); tick(0, 0);
    chk("R4 idle", bus_busy, 1'b0);
    tick(0, 1); tick(1, 1);
    do_start();
    tick(0, 1); tick(0, 0); tick(0, 1);
    chk("R4 busy", bus_busy, 1'b1);
    tick(0, 0);
    do_stop();
  endtask

  task automatic t_no_loss();
    logic l;
    mst_sda_oe = 1'b1;
    bit_cycle(1, 0, l);
    chk("R7 idle bus", l, 1'b0);
    do_start();
    bit_cycle(0, 0, l); chk("R7 drive0", l, 1'b0);
    bit_cycle(1, 1, l); chk("R7 match1", l, 1'b0);
    mst_sda_oe = 1'b0;
    bit_cycle(1, 0, l); chk("R7 oe off", l, 1'b0);
    mst_sda_oe = 1'b1;
    mst_sda_out = 1'b0;
    tick(0, 0); tick(1, 0);
    mst_sda_out = 1'b1;
    tick(1, 0); tick(1, 0);
    chk("R9 mid-high", arb_lost, 1'b0);
    chk("R9 release", force_release, 1'b0);
    tick(0, 0);
    mst_sda_oe = 1'b0;
    do_stop();
  endtask

  task automatic t_loss_data();
    logic l;
    do_start();
    mst_sda_oe = 1'b1;
    for (int i = 0; i < 13; i++) begin
      bit_cycle(i[0], i[0], l);
      chk("R10 match bit", l, 1'b0);
    end
    mst_sda_out = 1'b1;
    tick(0, 0); tick(1, 0);
    chk("R6 lost", arb_lost, 1'b1);
    chk("R8 release set", force_release, 1'b1);
    chk("R8 oe off", sda_oe_o, 1'b0);
    start_req = 1'b1; #1;
    chk("R5 grant locked", start_grant, 1'b0);
    start_req = 1'b0;
    tick(1, 0);
    chk("R6 one cycle", arb_lost, 1'b0);
    tick(0, 0);
    bit_cycle(1, 0, l);
    chk("R11 no reloss", l, 1'b0);
    chk("R8 hold", force_release, 1'b1);
    do_stop();
    chk("R8 release clr", force_release, 1'b0);
    chk("R8 busy clr", bus_busy, 1'b0);
    chk("R8 oe back", sda_oe_o, 1'b1);
    mst_sda_oe = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_start_stop();
    t_low_toggle();
    t_no_loss();
    t_loss_data();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule